// File: doc/BRIEF.md
# Instruction Address Sequencer with Trap Redirect

This block holds the architectural instruction address state of a 64-bit core: the address of the instruction now retiring (`cia`), the address that follows it (`nia`), a pair of save registers that capture state when a trap is taken, and the machine state word. Each retire pulse moves the core forward by one instruction. The move is sequential by default. A taken branch sends it to the branch target, and a trap request sends it to a trap vector.

A trap has priority over a branch reported by the same instruction. When a trap is taken, the block copies the trapping address into `srr0` and the machine state word into `srr1`. It then sets one cause bit in the machine state word. The cause index uses most-significant-first numbering, so index k selects bit 63-k counted from the least significant bit. The vector is either the built-in default, 0x700, or an address supplied with the request. The default serves both explicit trap instructions and illegal-instruction traps.

A synchronous reset loads a start address into `cia` and that address plus 4 into `nia`.

Top module: `instr_addr_unit`

## Requirements
- R1: While `rstN` is low at a clock edge, `cia` takes `startAddr`, `nia` takes `startAddr`+4, and `srr0`, `srr1` and `msr` become zero.
- R2: After every clock edge, `nia` equals `cia`+4 modulo 2^64.
- R3: A retire with neither `branchTaken` nor `trapReq` set loads `cia` with the previous `nia`.
- R4: A retire with `branchTaken` high and `trapReq` low loads `cia` with `branchTarget`.
- R5: A retire with `trapReq` high loads `cia` with the trap vector, whatever the value of `branchTaken` or `branchTarget`.
- R6: The trap vector is 0x700 when `trapUseVec` is 0, and `trapVec` when `trapUseVec` is 1.
- R7: A retire with a trap loads `srr0` with the previous `cia` and `srr1` with the previous `msr`.
- R8: A retire with a trap ORs into `msr` the single bit at LSB position 63-`trapCause`. All other `msr` bits keep their values.
- R9: While `retire` is low, all five outputs hold their values. Branch and trap inputs have no effect.
- R10: A retire without a trap leaves `srr0`, `srr1` and `msr` unchanged.
- R11: Address arithmetic wraps modulo 2^64. After a branch to 0xFFFF_FFFF_FFFF_FFFC, `nia` is 0 and the next sequential retire gives `cia` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| startAddr | input | 64 | Address loaded into `cia` during reset |
| retire | input | 1 | One instruction retires this cycle |
| branchTaken | input | 1 | The retiring instruction redirects to `branchTarget` |
| branchTarget | input | 64 | Branch destination |
| trapReq | input | 1 | The retiring instruction traps |
| trapUseVec | input | 1 | 1: use `trapVec`; 0: use the default vector 0x700 |
| trapVec | input | 64 | Supplied trap vector |
| trapCause | input | 6 | Cause index, most-significant-first numbering |
| cia | output | 64 | Current instruction address |
| nia | output | 64 | Next instruction address |
| srr0 | output | 64 | Address saved on trap |
| srr1 | output | 64 | Machine state saved on trap |
| msr | output | 64 | Machine state word |

## Verification
The bench sweeps every cause index with both vector selections while the machine state word keeps accumulating bits. This exposes three kinds of fault:
- a design that counts the cause from the least significant bit;
- a design that clears other bits;
- a design that saves the updated state rather than the old one.

Other stimuli target further faults. One instruction raises a branch and a trap together, so a design that gives the branch priority lands on the target instead of the vector. Retire-low cycles carry live branch and trap inputs, and any leak shows as a moved address or a changed save register. A branch to the top of the address space tests that `nia` and the following address wrap to zero rather than saturating. A second reset in mid-run checks that the start address is reloaded.

// File: rtl/pc_trap_pkg.sv
package pc_trap_pkg;

  // Strobes from the control decision to the address datapath.
  typedef struct packed {
    logic load;        // an instruction retires this cycle
    logic takeBranch;  // redirect to branch target
    logic takeTrap;    // redirect to trap vector and save state
    logic useDefVec;   // trap vector is the built-in default
  } pcCtl_t;

endpackage

// File: rtl/pc_trap_ctrl.sv
module pc_trap_ctrl
  import pc_trap_pkg::*;
(
  input  logic   retire,
  input  logic   branchTaken,
  input  logic   trapReq,
  input  logic   trapUseVec,
  output pcCtl_t ctl
);

  // A trap wins over a branch from the same instruction; both need retire.
  always_comb begin
    ctl.load       = retire;
    ctl.takeTrap   = retire & trapReq;
    ctl.takeBranch = retire & branchTaken & ~trapReq;
    ctl.useDefVec  = ~trapUseVec;
  end

endmodule

// File: rtl/pc_trap_dp.sv
module pc_trap_dp
  import pc_trap_pkg::*;
#(
  parameter int                ADDR_W  = 64,
  parameter int                STEP    = 4,
  parameter logic [ADDR_W-1:0] DEF_VEC = 'h700,
  localparam int               CAUSE_W = $clog2(ADDR_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  startAddr,
  input  pcCtl_t             ctl,
  input  logic [ADDR_W-1:0]  branchTarget,
  input  logic [ADDR_W-1:0]  trapVec,
  input  logic [CAUSE_W-1:0] trapCause,
  output logic [ADDR_W-1:0]  cia,
  output logic [ADDR_W-1:0]  nia,
  output logic [ADDR_W-1:0]  srr0,
  output logic [ADDR_W-1:0]  srr1,
  output logic [ADDR_W-1:0]  msr
);

  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  logic [ADDR_W-1:0] vecSel;
  logic [ADDR_W-1:0] ciaNext;
  logic [ADDR_W-1:0] causeMask;

  assign vecSel = ctl.useDefVec ? DEF_VEC : trapVec;

  always_comb begin
    if (ctl.takeTrap)        ciaNext = vecSel;
    else if (ctl.takeBranch) ciaNext = branchTarget;
    else                     ciaNext = nia;
  end

  // Cause index counts from the MSB: index k maps to LSB position W-1-k.
  for (genvar i = 0; i < ADDR_W; i++) begin : g_cause
    assign causeMask[i] = (trapCause == CAUSE_W'(ADDR_W - 1 - i));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cia  <= startAddr;
      nia  <= startAddr + STEP_V;
      srr0 <= '0;
      srr1 <= '0;
      msr  <= '0;
    end else if (ctl.load) begin
      cia <= ciaNext;
      nia <= ciaNext + STEP_V;
      if (ctl.takeTrap) begin
        srr0 <= cia;
        srr1 <= msr;
        msr  <= msr | causeMask;
      end
    end
  end

endmodule

// File: rtl/instr_addr_unit.sv
module instr_addr_unit
  import pc_trap_pkg::*;
#(
  parameter int                ADDR_W  = 64,
  parameter int                STEP    = 4,
  parameter logic [ADDR_W-1:0] DEF_VEC = 'h700,
  localparam int               CAUSE_W = $clog2(ADDR_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  startAddr,
  input  logic               retire,
  input  logic               branchTaken,
  input  logic [ADDR_W-1:0]  branchTarget,
  input  logic               trapReq,
  input  logic               trapUseVec,
  input  logic [ADDR_W-1:0]  trapVec,
  input  logic [CAUSE_W-1:0] trapCause,
  output logic [ADDR_W-1:0]  cia,
  output logic [ADDR_W-1:0]  nia,
  output logic [ADDR_W-1:0]  srr0,
  output logic [ADDR_W-1:0]  srr1,
  output logic [ADDR_W-1:0]  msr
);

  pcCtl_t ctl;

  pc_trap_ctrl u_ctrl (
    .retire      (retire),
    .branchTaken (branchTaken),
    .trapReq     (trapReq),
    .trapUseVec  (trapUseVec),
    .ctl         (ctl)
  );

  pc_trap_dp #(
    .ADDR_W  (ADDR_W),
    .STEP    (STEP),
    .DEF_VEC (DEF_VEC)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .startAddr    (startAddr),
    .ctl          (ctl),
    .branchTarget (branchTarget),
    .trapVec      (trapVec),
    .trapCause    (trapCause),
    .cia          (cia),
    .nia          (nia),
    .srr0         (srr0),
    .srr1         (srr1),
    .msr          (msr)
  );

endmodule

// File: rtl/instr_addr_unit_chk.sv
module instr_addr_unit_chk #(
  parameter int                ADDR_W  = 64,
  parameter int                STEP    = 4,
  parameter logic [ADDR_W-1:0] DEF_VEC = 'h700,
  localparam int               CAUSE_W = $clog2(ADDR_W)
) (
  input logic               clk,
  input logic               rstN,
  input logic               retire,
  input logic               branchTaken,
  input logic [ADDR_W-1:0]  branchTarget,
  input logic               trapReq,
  input logic               trapUseVec,
  input logic [ADDR_W-1:0]  trapVec,
  input logic [CAUSE_W-1:0] trapCause,
  input logic [ADDR_W-1:0]  cia,
  input logic [ADDR_W-1:0]  nia,
  input logic [ADDR_W-1:0]  srr0,
  input logic [ADDR_W-1:0]  srr1,
  input logic [ADDR_W-1:0]  msr
);

  logic [ADDR_W-1:0] maskQ;
  logic [ADDR_W-1:0] vecQ;

  // Expected cause bit and vector captured from the inputs at the same edge.
  always_ff @(posedge clk) begin
    maskQ <= ADDR_W'(1) << (CAUSE_W'(ADDR_W - 1) - trapCause);
    vecQ  <= trapUseVec ? trapVec : DEF_VEC;
  end

  a_r2_nia_step: assert property (@(posedge clk) disable iff (!rstN)
    retire |=> nia == cia + ADDR_W'(STEP));

  a_r3_sequential: assert property (@(posedge clk) disable iff (!rstN)
    (retire && !branchTaken && !trapReq) |=> cia == $past(nia));

  a_r4_branch: assert property (@(posedge clk) disable iff (!rstN)
    (retire && branchTaken && !trapReq) |=> cia == $past(branchTarget));

  a_r5_trap_vector: assert property (@(posedge clk) disable iff (!rstN)
    (retire && trapReq) |=> cia == vecQ);

  a_r7_save: assert property (@(posedge clk) disable iff (!rstN)
    (retire && trapReq) |=> (srr0 == $past(cia)) && (srr1 == $past(msr)));

  a_r8_cause_bit: assert property (@(posedge clk) disable iff (!rstN)
    (retire && trapReq) |=> msr == ($past(msr) | maskQ));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !retire |=> $stable(cia) && $stable(nia) && $stable(srr0)
                && $stable(srr1) && $stable(msr));

  a_r10_no_save: assert property (@(posedge clk) disable iff (!rstN)
    (retire && !trapReq) |=> $stable(srr0) && $stable(srr1) && $stable(msr));

endmodule

bind instr_addr_unit instr_addr_unit_chk #(
  .ADDR_W  (ADDR_W),
  .STEP    (STEP),
  .DEF_VEC (DEF_VEC)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .retire       (retire),
  .branchTaken  (branchTaken),
  .branchTarget (branchTarget),
  .trapReq      (trapReq),
  .trapUseVec   (trapUseVec),
  .trapVec      (trapVec),
  .trapCause    (trapCause),
  .cia          (cia),
  .nia          (nia),
  .srr0         (srr0),
  .srr1         (srr1),
  .msr          (msr)
);

// File: tb/instr_addr_unit_tb.sv
module instr_addr_unit_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] startAddr = '0;
  logic        retire = 1'b0;
  logic        branchTaken = 1'b0;
  logic [63:0] branchTarget = '0;
  logic        trapReq = 1'b0;
  logic        trapUseVec = 1'b0;
  logic [63:0] trapVec = '0;
  logic [5:0]  trapCause = '0;
  logic [63:0] cia, nia, srr0, srr1, msr;

  int nChecks = 0;
  int nErr = 0;

  // Reference state kept by the bench
  logic [63:0] mCia, mSrr0, mSrr1, mMsr;

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_addr_unit u_dut (
    .clk(clk), .rstN(rstN), .startAddr(startAddr), .retire(retire),
    .branchTaken(branchTaken), .branchTarget(branchTarget),
    .trapReq(trapReq), .trapUseVec(trapUseVec), .trapVec(trapVec),
    .trapCause(trapCause), .cia(cia), .nia(nia), .srr0(srr0),
    .srr1(srr1), .msr(msr)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string ciaReq, input string saveReq);
    chk(ciaReq, "cia", cia, mCia);
    chk("R2", "nia", nia, mCia + 64'd4);
    chk(saveReq, "srr0", srr0, mSrr0);
    chk(saveReq, "srr1", srr1, mSrr1);
    chk(saveReq, "msr", msr, mMsr);
  endtask

  task automatic doReset(input logic [63:0] start);
    @(negedge clk);
    rstN = 1'b0; retire = 1'b0; startAddr = start;
    @(posedge clk); #1;
    mCia = start; mSrr0 = '0; mSrr1 = '0; mMsr = '0;
    checkAll("R1", "R1");
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic step(input bit r, input bit b, input logic [63:0] t,
                      input bit tr, input bit uv, input logic [63:0] v,
                      input logic [5:0] c,
                      input string ciaReq, input string saveReq);
    @(negedge clk);
    retire = r; branchTaken = b; branchTarget = t;
    trapReq = tr; trapUseVec = uv; trapVec = v; trapCause = c;
    if (r) begin
      if (tr) begin
        mSrr0 = mCia;
        mSrr1 = mMsr;
        mMsr  = mMsr | (64'd1 << (63 - int'(c)));
        mCia  = uv ? v : 64'h700;
      end else if (b) begin
        mCia = t;
      end else begin
        mCia = mCia + 64'd4;
      end
    end
    @(posedge clk); #1;
    checkAll(ciaReq, saveReq);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nErr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    doReset(64'h1000);
    // R3: plain sequential retires
    for (int i = 0; i < 5; i++)
      step(1, 0, '0, 0, 0, '0, '0, "R3", "R10");
    // R9: retire low with live branch and trap inputs
    step(0, 1, 64'hDEAD_0000, 1, 1, 64'hBEEF_0000, 6'd5, "R9", "R9");
    step(0, 0, '0, 1, 0, '0, 6'd0, "R9", "R9");
    // R4: branch
    step(1, 1, 64'h0000_0000_0004_2000, 0, 0, '0, '0, "R4", "R10");
    step(1, 0, '0, 0, 0, '0, '0, "R3", "R10");
    // R5/R6: trap and branch together, default vector
    step(1, 1, 64'h9999_0000, 1, 0, 64'h5555_0000, 6'd0, "R5 R6", "R7 R8");
    // R10: branch after a trap keeps save registers and state
    step(1, 1, 64'h3000, 0, 0, '0, '0, "R4", "R10");
    // R8 R7 R6: every cause index, alternating vector selection
    for (int c = 0; c < 64; c++) begin
      step(1, c[0], 64'h7777_0000, 1, c[1], 64'h0001_0000 + 64'(c * 256),
           6'(c), "R5 R6", "R7 R8");
      step(1, 0, '0, 0, 0, '0, '0, "R3", "R10");
    end
    // R9 after state is full
    step(0, 1, 64'h1234, 1, 0, '0, 6'd63, "R9", "R9");
    // R11: wrap at the top of the address space
    step(1, 1, 64'hFFFF_FFFF_FFFF_FFFC, 0, 0, '0, '0, "R11", "R10");
    step(1, 0, '0, 0, 0, '0, '0, "R11", "R10");
    // R1: reset again in mid-run
    doReset(64'h0000_0000_8000_0040);
    step(1, 0, '0, 0, 0, '0, '0, "R3", "R10");
    step(1, 0, '0, 1, 1, 64'h0000_0000_0000_0100, 6'd63, "R6", "R7 R8");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule